// File: doc/BRIEF.md
# Link Bring-Up Speed Sequencer

This block steps a serial link from reset to its final negotiated rate. It drives the control-register fields that govern training and polls the status indications that come back. A start pulse launches the sequence. The block first caps the maximum link rate at the first generation and then enables the training state machine. It waits for link-up, and only then raises the rate cap to the second generation. It next requests a directed speed change and waits for that request to clear. A final link-up check confirms that retraining is finished. The register file and the training logic sit outside the block.

Every wait advances only on a poll tick, which usually comes from a slow timebase. Each of the three waits allows at most `POLL_LIMIT` polls. Its retry counter restarts at zero whenever a new step is entered. The outcome is a one-cycle `done_o` pulse that comes with the captured generation number, or a one-cycle `fail_o` pulse. The current-speed input is the 4-bit generation field, which lives at bits [19:16] of the link status word. Logic outside the block extracts it.

Top module: `lnk_speed_seq`

## Requirements
- R1: After reset, `max_spd_o`, `final_spd_o`, `train_en_o`, `spd_chg_req_o`, `done_o` and `fail_o` are all 0.
- R2: A start accepted in idle sets `max_spd_o` to 1 (first generation) at the next edge, with `train_en_o` low. `train_en_o` goes to 1 at the edge after that.
- R3: During the first link-up wait, only cycles with `poll_tick_i` high sample `link_up_i`. The first such poll that sees link-up sets `max_spd_o` to 2 (second generation) at that edge.
- R4: In the cycle that follows the rise of `max_spd_o` to 2, `spd_chg_req_o` is high for exactly one cycle.
- R5: The speed-change wait ends at the first poll tick on which `spd_chg_pend_i` is 0. `link_up_i` and `spd_chg_pend_i` have no effect on cycles without a poll tick.
- R6: In the second link-up wait, the first poll tick with `link_up_i` high produces a `done_o` pulse at that edge. At the same edge `final_spd_o` takes the value of `cur_spd_i` as it was on that poll.
- R7: If a wait sees `POLL_LIMIT` polls without success, `fail_o` pulses at the edge of the last poll and `train_en_o` returns to 0 at that same edge.
- R8: The retry count is cleared each time a wait step is entered, so every wait gets the full `POLL_LIMIT` polls no matter how many polls earlier waits used.
- R9: A start that arrives while a sequence is running (from acceptance until the `done_o` or `fail_o` pulse) is ignored. `max_spd_o` and `train_en_o` keep their values.
- R10: `done_o` and `fail_o` are each one cycle long and are never high together. After `done_o`, `train_en_o` stays 1 and `max_spd_o` stays 2 until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| poll_tick_i | input | 1 | Poll strobe; waits sample their status only on this |
| link_up_i | input | 1 | Link is up and training finished |
| spd_chg_pend_i | input | 1 | Directed speed change still pending (readback of the request bit) |
| cur_spd_i | input | SPD_W | Current link generation field from the status word |
| max_spd_o | output | SPD_W | Maximum link speed field to write |
| train_en_o | output | 1 | Training state machine enable |
| spd_chg_req_o | output | 1 | One-cycle request to set the directed speed change bit |
| done_o | output | 1 | One-cycle success pulse |
| fail_o | output | 1 | One-cycle timeout pulse |
| final_spd_o | output | SPD_W | Generation captured on success |

## Verification
A corrupted step state would show up at the ports within one or two cycles. The symptoms would be a missing or misplaced speed-change request, a rate cap raised too early, or a done pulse with no preceding request. A corrupted retry counter stays hidden until the poll on which a wait should have failed or succeeded. At that point the fail pulse comes early, comes late or never comes. The bench therefore sweeps the poll index of success in each of the three waits, from the first poll up to beyond the limit, so that every counter value meets both outcomes.

// File: rtl/lss_pkg.sv
package lss_pkg;
  typedef enum logic [3:0] {
    S_IDLE  = 4'd0,
    S_CAP   = 4'd1,
    S_WUP1  = 4'd2,
    S_RAISE = 4'd3,
    S_REQ   = 4'd4,
    S_WCHG  = 4'd5,
    S_WUP2  = 4'd6,
    S_DONE  = 4'd7,
    S_FAIL  = 4'd8
  } lss_state_t;

  localparam int unsigned GEN1_CODE = 1;
  localparam int unsigned GEN2_CODE = 2;
endpackage

// File: rtl/lss_retry_cnt.sv
module lss_retry_cnt #(
  parameter int unsigned POLL_LIMIT = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic miss_i,
  output logic last_o
);
  localparam int unsigned CW = (POLL_LIMIT < 2) ? 1 : $clog2(POLL_LIMIT);
  localparam logic [CW-1:0] LAST_VAL = CW'(POLL_LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr_i | miss_i;
    cnt_d  = clr_i ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign last_o = (cnt_q == LAST_VAL);
endmodule

// File: rtl/lss_fsm.sv
module lss_fsm
  import lss_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       tick_i,
  input  logic       link_up_i,
  input  logic       pend_i,
  input  logic       last_i,
  output lss_state_t state_q_o,
  output lss_state_t state_d_o,
  output logic       miss_o
);
  lss_state_t st_q;
  lss_state_t st_d;
  logic       ok;
  logic       waiting;

  always_comb begin
    ok      = (st_q == S_WCHG) ? !pend_i : link_up_i;
    waiting = (st_q == S_WUP1) || (st_q == S_WCHG) || (st_q == S_WUP2);
    miss_o  = waiting && tick_i && !ok;
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE:  if (start_i) st_d = S_CAP;
      S_CAP:   st_d = S_WUP1;
      S_WUP1: begin
        if (tick_i) begin
          if (ok)          st_d = S_RAISE;
          else if (last_i) st_d = S_FAIL;
        end
      end
      S_RAISE: st_d = S_REQ;
      S_REQ:   st_d = S_WCHG;
      S_WCHG: begin
        if (tick_i) begin
          if (ok)          st_d = S_WUP2;
          else if (last_i) st_d = S_FAIL;
        end
      end
      S_WUP2: begin
        if (tick_i) begin
          if (ok)          st_d = S_DONE;
          else if (last_i) st_d = S_FAIL;
        end
      end
      S_DONE:  st_d = S_IDLE;
      S_FAIL:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  assign state_q_o = st_q;
  assign state_d_o = st_d;
endmodule

// File: rtl/lss_ctrl_regs.sv
module lss_ctrl_regs
  import lss_pkg::*;
#(
  parameter int unsigned SPD_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  lss_state_t       state_q_i,
  input  lss_state_t       state_d_i,
  input  logic [SPD_W-1:0] cur_spd_i,
  output logic [SPD_W-1:0] max_spd_o,
  output logic             train_en_o,
  output logic [SPD_W-1:0] final_spd_o
);
  logic             cap_g1;
  logic             cap_g2;
  logic             en_set;
  logic             en_clr;
  logic             fin_cap;
  logic [SPD_W-1:0] max_d;
  logic             max_en;
  logic             ten_en;

  always_comb begin
    cap_g1  = (state_q_i == S_IDLE) && (state_d_i == S_CAP);
    cap_g2  = (state_q_i == S_WUP1) && (state_d_i == S_RAISE);
    en_set  = (state_q_i == S_CAP)  && (state_d_i == S_WUP1);
    en_clr  = cap_g1 || (state_d_i == S_FAIL);
    fin_cap = (state_q_i == S_WUP2) && (state_d_i == S_DONE);
    max_en  = cap_g1 || cap_g2;
    max_d   = cap_g1 ? SPD_W'(GEN1_CODE) : SPD_W'(GEN2_CODE);
    ten_en  = en_set || en_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      max_spd_o <= '0;
    end else if (max_en) begin
      max_spd_o <= max_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      train_en_o <= 1'b0;
    end else if (ten_en) begin
      train_en_o <= en_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      final_spd_o <= '0;
    end else if (fin_cap) begin
      final_spd_o <= cur_spd_i;
    end
  end
endmodule

// File: rtl/lnk_speed_seq.sv
module lnk_speed_seq
  import lss_pkg::*;
#(
  parameter int unsigned POLL_LIMIT = 200,
  parameter int unsigned SPD_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             poll_tick_i,
  input  logic             link_up_i,
  input  logic             spd_chg_pend_i,
  input  logic [SPD_W-1:0] cur_spd_i,
  output logic [SPD_W-1:0] max_spd_o,
  output logic             train_en_o,
  output logic             spd_chg_req_o,
  output logic             done_o,
  output logic             fail_o,
  output logic [SPD_W-1:0] final_spd_o
);
  lss_state_t st_q;
  lss_state_t st_d;
  logic       miss;
  logic       last;
  logic       step_entry;

  assign step_entry = (st_d != st_q);

  lss_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .tick_i    (poll_tick_i),
    .link_up_i (link_up_i),
    .pend_i    (spd_chg_pend_i),
    .last_i    (last),
    .state_q_o (st_q),
    .state_d_o (st_d),
    .miss_o    (miss)
  );

  lss_retry_cnt #(.POLL_LIMIT(POLL_LIMIT)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (step_entry),
    .miss_i (miss),
    .last_o (last)
  );

  lss_ctrl_regs #(.SPD_W(SPD_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .state_q_i   (st_q),
    .state_d_i   (st_d),
    .cur_spd_i   (cur_spd_i),
    .max_spd_o   (max_spd_o),
    .train_en_o  (train_en_o),
    .final_spd_o (final_spd_o)
  );

  assign spd_chg_req_o = (st_q == S_REQ);
  assign done_o        = (st_q == S_DONE);
  assign fail_o        = (st_q == S_FAIL);
endmodule

// File: rtl/lnk_speed_seq_chk.sv
module lnk_speed_seq_chk #(
  parameter int unsigned SPD_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SPD_W-1:0] max_spd_o,
  input logic             train_en_o,
  input logic             spd_chg_req_o,
  input logic             done_o,
  input logic             fail_o
);
  p_done_fail_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && fail_o));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_fail_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |=> !fail_o);

  p_cap_before_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(train_en_o) |-> (max_spd_o == SPD_W'(1)));

  p_req_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    spd_chg_req_o |=> !spd_chg_req_o);

  p_req_after_raise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    spd_chg_req_o |-> (max_spd_o == SPD_W'(2)) && train_en_o);

  p_done_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> train_en_o && (max_spd_o == SPD_W'(2)));

  p_fail_drops_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |-> !train_en_o);
endmodule

bind lnk_speed_seq lnk_speed_seq_chk #(.SPD_W(SPD_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .max_spd_o     (max_spd_o),
  .train_en_o    (train_en_o),
  .spd_chg_req_o (spd_chg_req_o),
  .done_o        (done_o),
  .fail_o        (fail_o)
);

// File: tb/lnk_speed_seq_tb_top.sv
module lnk_speed_seq_tb_top;
  localparam int unsigned LIM = 4;
  localparam int unsigned SW  = 4;

  logic          clk;
  logic          rst_n;
  logic          start_i;
  logic          poll_tick_i;
  logic          link_up_i;
  logic          spd_chg_pend_i;
  logic [SW-1:0] cur_spd_i;
  logic [SW-1:0] max_spd_o;
  logic          train_en_o;
  logic          spd_chg_req_o;
  logic          done_o;
  logic          fail_o;
  logic [SW-1:0] final_spd_o;

  int n_chk;
  int n_bad;

  lnk_speed_seq #(.POLL_LIMIT(LIM), .SPD_W(SW)) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .poll_tick_i    (poll_tick_i),
    .link_up_i      (link_up_i),
    .spd_chg_pend_i (spd_chg_pend_i),
    .cur_spd_i      (cur_spd_i),
    .max_spd_o      (max_spd_o),
    .train_en_o     (train_en_o),
    .spd_chg_req_o  (spd_chg_req_o),
    .done_o         (done_o),
    .fail_o         (fail_o),
    .final_spd_o    (final_spd_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    report();
  end

  // One poll: tick high for one edge with the given status, then sample.
  task automatic poll(input bit up, input bit pend, input logic [SW-1:0] spd);
    poll_tick_i    = 1'b1;
    link_up_i      = up;
    spd_chg_pend_i = pend;
    cur_spd_i      = spd;
    @(negedge clk);
    poll_tick_i = 1'b0;
  endtask

  // Gap cycle without a tick, driving misleading status (R5 / R9 stimulus).
  task automatic gap(input bit do_start);
    link_up_i      = 1'b1;
    spd_chg_pend_i = 1'b0;
    cur_spd_i      = 4'hF;
    start_i        = do_start;
    @(negedge clk);
    start_i        = 1'b0;
  endtask

  task automatic run_case(input int a, input int b, input int c, input logic [SW-1:0] gen);
    bit ok1;
    bit ok2;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(max_spd_o == 4'd1, "R2 cap gen1", max_spd_o, 1);
    chk(train_en_o == 1'b0, "R2 enable waits", train_en_o, 0);
    @(negedge clk);
    chk(train_en_o == 1'b1, "R2 enable", train_en_o, 1);

    ok1 = 1'b0;
    for (int i = 1; i <= int'(LIM); i++) begin
      poll(i >= a, 1'b1, 4'd0);
      if (i >= a) begin
        chk(max_spd_o == 4'd2, "R3 raise gen2", max_spd_o, 2);
        chk(fail_o == 1'b0, "R3 no fail", fail_o, 0);
        ok1 = 1'b1;
        break;
      end else if (i == int'(LIM)) begin
        chk(fail_o == 1'b1, "R7 fail wait1", fail_o, 1);
        chk(train_en_o == 1'b0, "R7 enable drop", train_en_o, 0);
      end else begin
        chk(max_spd_o == 4'd1 && !fail_o, "R3 still capped", max_spd_o, 1);
        gap(1'b0);
        chk(max_spd_o == 4'd1, "R3 no tick no advance", max_spd_o, 1);
      end
    end
    if (!ok1) begin
      @(negedge clk);
      chk(fail_o == 1'b0, "R10 fail one cycle", fail_o, 0);
      return;
    end

    @(negedge clk);
    chk(spd_chg_req_o == 1'b1, "R4 request", spd_chg_req_o, 1);
    @(negedge clk);
    chk(spd_chg_req_o == 1'b0, "R4 request one cycle", spd_chg_req_o, 0);

    ok2 = 1'b0;
    for (int i = 1; i <= int'(LIM); i++) begin
      poll(1'b0, !(i >= b), 4'd0);
      if (i >= b) begin
        chk(fail_o == 1'b0 && !done_o, "R5 change complete", fail_o, 0);
        ok2 = 1'b1;
        break;
      end else if (i == int'(LIM)) begin
        chk(fail_o == 1'b1, "R8 fail wait2 full limit", fail_o, 1);
        chk(train_en_o == 1'b0, "R7 enable drop", train_en_o, 0);
      end else begin
        chk(fail_o == 1'b0, "R8 wait2 not early", fail_o, 1'b0);
        gap(i == 1);
        chk(max_spd_o == 4'd2 && train_en_o, "R9 start ignored", max_spd_o, 2);
        chk(spd_chg_req_o == 1'b0, "R5 no tick no advance", spd_chg_req_o, 0);
      end
    end
    if (!ok2) begin
      @(negedge clk);
      chk(fail_o == 1'b0, "R10 fail one cycle", fail_o, 0);
      return;
    end

    for (int i = 1; i <= int'(LIM); i++) begin
      poll(i >= c, 1'b1, gen);
      if (i >= c) begin
        chk(done_o == 1'b1 && !fail_o, "R6 done", done_o, 1);
        chk(final_spd_o == gen, "R6 final speed", final_spd_o, gen);
        @(negedge clk);
        chk(done_o == 1'b0, "R10 done one cycle", done_o, 0);
        chk(train_en_o && max_spd_o == 4'd2, "R10 held after done", max_spd_o, 2);
        return;
      end else if (i == int'(LIM)) begin
        chk(fail_o == 1'b1 && !done_o, "R8 fail wait3 full limit", fail_o, 1);
        @(negedge clk);
        chk(fail_o == 1'b0, "R10 fail one cycle", fail_o, 0);
      end else begin
        chk(done_o == 1'b0 && !fail_o, "R6 not yet", done_o, 0);
        gap(1'b0);
        chk(done_o == 1'b0, "R6 no tick no done", done_o, 0);
      end
    end
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    start_i = 1'b0;
    poll_tick_i = 1'b0;
    link_up_i = 1'b0;
    spd_chg_pend_i = 1'b1;
    cur_spd_i = '0;
    repeat (3) @(negedge clk);
    chk(max_spd_o == 0 && final_spd_o == 0, "R1 reset speeds", max_spd_o, 0);
    chk(!train_en_o && !spd_chg_req_o && !done_o && !fail_o, "R1 reset flags",
        train_en_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // Ticks while idle do nothing.
    poll(1'b1, 1'b0, 4'd3);
    chk(max_spd_o == 0 && !train_en_o, "R1 idle ignores polls", max_spd_o, 0);

    for (int a = 1; a <= int'(LIM) + 1; a++) begin
      for (int b = 1; b <= int'(LIM) + 1; b++) begin
        for (int c = 1; c <= int'(LIM) + 1; c++) begin
          if (a > int'(LIM) && (b > 1 || c > 1)) continue;
          if (b > int'(LIM) && c > 1) continue;
          run_case(a, b, c, SW'((a * 7 + b * 3 + c) % 16));
          repeat (2) @(negedge clk);
        end
      end
    end
    report();
  end
endmodule